// File: doc/BRIEF.md
# Serial-Bus Activity Watchdog

This block watches over a host processor without needing a separate service pin. It samples the data and clock lines of a two-wire serial bus (SDA, SCL) and treats one full bus transaction as proof that the host is alive. A transaction here means a START condition that is later closed by a STOP condition. Each such transaction restarts a timeout counter. If no transaction completes before the selected period runs out, an active-low watchdog output is pulled low. It stays low until the next completed transaction, or until a new period is written.

Both bus lines are sampled by the block's own clock, which runs much faster than the bus. They pass through a synchronizer before any edge is judged. A two-bit period select chooses one of three timeout lengths, or turns the watchdog off. The select is loaded through a simple write strobe, which the surrounding serial-bus slave logic drives when the host writes the control register.

Top module: `bus_watchdog`

## Requirements
- R1: A synchronous active-low reset drives `wdo_n_o` high, selects period code 00 and restarts the count. After reset with no bus activity, `wdo_n_o` falls on the 16th rising edge after the last edge that sampled reset low.
- R2: A START with no later STOP does not restart the timer. A STOP with no pending START does not restart it either.
- R3: A valid service releases `wdo_n_o` (drives it high) and restarts the count. A valid service is a START (SDA falls while SCL is high) followed by a STOP (SDA rises while SCL is high). The release happens on the third rising edge counted from the first edge that samples the STOP-forming rise of SDA.
- R4: With period code 00, `wdo_n_o` falls exactly 16 rising edges after the edge that restarted the count.
- R5: Period code 01 gives 64 edges and period code 10 gives 256 edges, both measured the same way as in R4.
- R6: Period code 11 disables the watchdog. `wdo_n_o` stays high and the count is held at zero.
- R7: A repeated START that arrives before the STOP keeps the pending state armed. The following STOP then counts as a valid service.
- R8: A change on SDA while SCL is low is neither a START nor a STOP.
- R9: A write of the period select (`per_wr_i` high at a rising edge) loads `per_sel_i`, restarts the count and releases `wdo_n_o` on that same edge.
- R10: Once `wdo_n_o` is low, it stays low until a valid service or a period write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, much faster than the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| sda_i | input | 1 | Serial data line, asynchronous to clk |
| scl_i | input | 1 | Serial clock line, asynchronous to clk |
| per_wr_i | input | 1 | Period select write strobe |
| per_sel_i | input | 2 | New period code: 00/01/10 select a length, 11 disables |
| wdo_n_o | output | 1 | Watchdog output, low when a timeout has occurred |

## Verification
A bus change takes effect three rising edges after it is first sampled: two edges in the synchronizer and one in the condition register. A period write or a reset takes effect on the edge that samples it. A timeout appears exactly as many edges after a restart as the selected period. The bench drives all inputs at falling edges. A behavioural model advances on each rising edge, and its output is compared with `wdo_n_o` at every falling edge. The directed checks count edges from the restarting edge and sample on the falling edge just before the expected change and again just after it, so any error of a single cycle is caught.

// File: rtl/bw_pkg.sv
// Package: shared types for the serial-bus activity watchdog.
// Assumes: period codes are two bits wide. Code 11 is reserved for "off".
package bw_pkg;

    // Period select codes. Code 11 turns the watchdog off.
    typedef enum logic [1:0] {
        PER_SHORT = 2'b00,
        PER_MID   = 2'b01,
        PER_LONG  = 2'b10,
        PER_OFF   = 2'b11
    } per_sel_e;

    // One sample of the two bus lines.
    typedef struct packed {
        logic sda;
        logic scl;
    } bus_lines_t;

endpackage

// File: rtl/bw_sync.sv
// Module: multi-stage synchronizer for a group of asynchronous lines.
// Assumes: each line is sampled on its own, so skew between lines may cost
// one extra sample, which is harmless when clk is far faster than the bus.
// Reset loads RST_VAL so that an idle bus shows no edges after reset.
module bw_sync #(
    parameter int                 WIDTH   = 2,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    generate
        if (STAGES == 1) begin : g_single
            logic [WIDTH-1:0] stg_q;
            // Single capture stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q <= RST_VAL;
                else        stg_q <= d_i;
            end
            assign q_o = stg_q;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] stg_q;
            // Shift chain: index 0 captures, the top index feeds the output.
            always_ff @(posedge clk) begin
                if (!rst_n) stg_q <= {STAGES{RST_VAL}};
                else        stg_q <= {stg_q[STAGES-2:0], d_i};
            end
            assign q_o = stg_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/bw_cond_det.sv
// Module: bus START/STOP detector with a pending-transaction flag.
// Assumes: inputs are already synchronized. SCL must be high both in the
// previous and in the current sample for an SDA edge to count as a condition.
// A STOP raises service_o only when a START is pending.
module bw_cond_det
    import bw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bus_lines_t bus_i,
    output logic       service_o
);

    bus_lines_t prev_q;
    logic       pend_q;
    logic       start_c;
    logic       stop_c;

    // Previous sample register, idle-high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= bus_i;
    end

    // Condition decode from the previous and current samples.
    always_comb begin
        start_c = prev_q.sda & ~bus_i.sda & prev_q.scl & bus_i.scl;
        stop_c  = ~prev_q.sda & bus_i.sda & prev_q.scl & bus_i.scl;
    end

    // Pending flag: armed (or re-armed) by START, cleared by STOP.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= 1'b0;
        else if (start_c) pend_q <= 1'b1;
        else if (stop_c)  pend_q <= 1'b0;
    end

    // A completed transaction is a STOP that closes a pending START.
    assign service_o = stop_c & pend_q;

endmodule

// File: rtl/bw_timer.sv
// Module: period register, period decode and timeout counter.
// Assumes: service_i is a single-cycle pulse. A write and a service both
// restart the count. After a timeout the count freezes and the output
// stays low until the next restart.
module bw_timer
    import bw_pkg::*;
#(
    parameter int T_SHORT = 16,
    parameter int T_MID   = 64,
    parameter int T_LONG  = 256,
    parameter int CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             service_i,
    input  logic             wr_i,
    input  logic [1:0]       data_i,
    output logic             wdo_n_o
);

    per_sel_e         period_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_m1;
    logic             fired_q;
    logic             restart_c;

    // Period register, loaded by a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    period_q <= PER_SHORT;
        else if (wr_i) period_q <= per_sel_e'(data_i);
    end

    // Decode the last count value before a timeout for each code.
    always_comb begin
        unique case (period_q)
            PER_SHORT: lim_m1 = CNT_W'(T_SHORT - 1);
            PER_MID:   lim_m1 = CNT_W'(T_MID - 1);
            PER_LONG:  lim_m1 = CNT_W'(T_LONG - 1);
            default:   lim_m1 = '0;
        endcase
    end

    assign restart_c = wr_i | service_i | (period_q == PER_OFF);

    // Timeout counter and fired flag.
    always_ff @(posedge clk) begin
        if (!rst_n || restart_c) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
        end else if (!fired_q) begin
            if (cnt_q == lim_m1) fired_q <= 1'b1;
            else                 cnt_q   <= cnt_q + CNT_W'(1);
        end
    end

    assign wdo_n_o = ~fired_q;

endmodule

// File: rtl/bus_watchdog.sv
// Module: top level of the serial-bus activity watchdog.
// Assumes: clk oversamples SDA/SCL by a wide margin, and T_LONG is the
// largest period. The counter width comes from the largest period.
module bus_watchdog
    import bw_pkg::*;
#(
    parameter int T_SHORT     = 16,
    parameter int T_MID       = 64,
    parameter int T_LONG      = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_i,
    input  logic       scl_i,
    input  logic       per_wr_i,
    input  logic [1:0] per_sel_i,
    output logic       wdo_n_o
);

    localparam int MAX_T = (T_LONG > T_MID) ? ((T_LONG > T_SHORT) ? T_LONG : T_SHORT)
                                            : ((T_MID > T_SHORT) ? T_MID : T_SHORT);
    localparam int CNT_W = (MAX_T <= 2) ? 1 : $clog2(MAX_T);

    bus_lines_t raw_w;
    bus_lines_t sync_w;
    logic       svc_w;

    assign raw_w = '{sda: sda_i, scl: scl_i};

    bw_sync #(
        .WIDTH  ($bits(bus_lines_t)),
        .STAGES (SYNC_STAGES),
        .RST_VAL('1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (raw_w),
        .q_o  (sync_w)
    );

    bw_cond_det u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_i    (sync_w),
        .service_o(svc_w)
    );

    bw_timer #(
        .T_SHORT(T_SHORT),
        .T_MID  (T_MID),
        .T_LONG (T_LONG),
        .CNT_W  (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .service_i(svc_w),
        .wr_i     (per_wr_i),
        .data_i   (per_sel_i),
        .wdo_n_o  (wdo_n_o)
    );

endmodule

// File: rtl/bus_watchdog_chk.sv
// Module: property checker for bus_watchdog, attached with bind below.
// Assumes: its own copy of the period lengths is passed down from the top.
module bus_watchdog_chk #(
    parameter int T_SHORT = 16,
    parameter int T_MID   = 64,
    parameter int T_LONG  = 256,
    parameter int CNT_W   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wdo_n,
    input logic             wr,
    input logic             svc,
    input logic [1:0]       mode,
    input logic [CNT_W-1:0] cnt
);

    // Expected final count value for a mode, from the requirement table.
    function automatic int last_count(input logic [1:0] m);
        case (m)
            2'b00:   return T_SHORT - 1;
            2'b01:   return T_MID - 1;
            2'b10:   return T_LONG - 1;
            default: return 0;
        endcase
    endfunction

    p_reset_high_r1: assert property (@(posedge clk)
        !rst_n |=> wdo_n);

    p_service_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        svc |=> (wdo_n && cnt == '0));

    p_fall_at_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdo_n) |-> (int'(cnt) == last_count(mode)));

    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b11) |-> (int'(cnt) <= last_count(mode)));

    p_off_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |-> (wdo_n && cnt == '0));

    p_write_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (wdo_n && cnt == '0));

    p_hold_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdo_n && !svc && !wr) |=> !wdo_n);

endmodule

bind bus_watchdog bus_watchdog_chk #(
    .T_SHORT(T_SHORT),
    .T_MID  (T_MID),
    .T_LONG (T_LONG),
    .CNT_W  (CNT_W)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .wdo_n(wdo_n_o),
    .wr   (per_wr_i),
    .svc  (svc_w),
    .mode (u_timer.period_q),
    .cnt  (u_timer.cnt_q)
);

// File: tb/bus_watchdog_tb_top.sv
// Bench: a behavioural model compared with wdo_n_o on every falling edge,
// plus directed checks on each requirement.
module bus_watchdog_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sda = 1'b1;
    logic       scl = 1'b1;
    logic       wr = 1'b0;
    logic [1:0] sel = 2'b00;
    logic       wdo_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bus_watchdog dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_i    (sda),
        .scl_i    (scl),
        .per_wr_i (wr),
        .per_sel_i(sel),
        .wdo_n_o  (wdo_n)
    );

    // ---------------- reference model ----------------
    logic [1:0] hist[$];
    int  m_mode, m_cnt;
    bit  m_fired, m_pend, m_ready;

    function automatic int period_of(input int m);
        if (m == 0) return 16;
        if (m == 1) return 64;
        if (m == 2) return 256;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{2'b11, 2'b11, 2'b11};
            m_mode = 0; m_cnt = 0; m_fired = 0; m_pend = 0;
        end else begin
            bit st, sp, sv;
            logic [1:0] old_s, cur_s;
            old_s = hist[0];
            cur_s = hist[1];
            st = old_s[1] && !cur_s[1] && old_s[0] && cur_s[0];
            sp = !old_s[1] && cur_s[1] && old_s[0] && cur_s[0];
            sv = sp && m_pend;
            if (st) m_pend = 1; else if (sp) m_pend = 0;
            if (wr) begin
                m_mode = int'(sel); m_cnt = 0; m_fired = 0;
            end else if (sv || m_mode == 3) begin
                m_cnt = 0; m_fired = 0;
            end else if (!m_fired) begin
                if (m_cnt + 1 >= period_of(m_mode)) m_fired = 1;
                else m_cnt++;
            end
            hist.push_back({sda, scl});
            void'(hist.pop_front());
        end
        m_ready = 1;
    end

    always @(negedge clk) begin
        if (m_ready) begin
            checks++;
            if (wdo_n !== !m_fired) begin
                errors++;
                $display("FAIL R10 model compare at %0t: actual=%0b expected=%0b",
                         $time, wdo_n, !m_fired);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic hold(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_start();
        sda = 1'b1; scl = 1'b1; hold(3);
        sda = 1'b0; hold(3);
        scl = 1'b0; hold(3);
    endtask

    task automatic bus_stop();
        sda = 1'b0; hold(3);
        scl = 1'b1; hold(3);
        sda = 1'b1; hold(3);
    endtask

    task automatic data_bits(input int n);
        scl = 1'b0;
        for (int i = 0; i < n; i++) begin
            sda = ~sda; hold(2);
            scl = 1'b1; hold(2);
            scl = 1'b0; hold(2);
        end
    endtask

    // Write a period; returns at the falling edge right after the write edge.
    task automatic write_sel(input logic [1:0] v);
        @(negedge clk); wr = 1'b1; sel = v;
        @(negedge clk); wr = 1'b0;
    endtask

    // Restart edge just passed: expect a fall exactly n edges after it.
    task automatic expect_fall(input string tag, input int n);
        repeat (n - 1) @(posedge clk);
        @(negedge clk); chk({tag, " before limit"}, wdo_n, 1'b1);
        @(negedge clk); chk({tag, " at limit"}, wdo_n, 1'b0);
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        hold(3);
        rst_n = 1'b1;
        chk("R1 released after reset", wdo_n, 1'b1);
        expect_fall("R1 R4 period 00 after reset", 16);

        // R3: valid service with exact latency.
        bus_start();
        sda = 1'b0; hold(3);
        scl = 1'b1; hold(3);
        sda = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R3 not yet released", wdo_n, 1'b0);
        @(negedge clk);
        chk("R3 released by service", wdo_n, 1'b1);

        // R2: START without STOP leaves the timeout in place.
        hold(20);
        bus_start();
        data_bits(4);
        hold(5);
        chk("R2 start alone", wdo_n, 1'b0);
        bus_stop();
        chk("R3 stop closes pending start", wdo_n, 1'b1);

        // R2: STOP with nothing pending.
        hold(20);
        scl = 1'b0; hold(2);
        bus_stop();
        hold(3);
        chk("R2 stop alone", wdo_n, 1'b0);

        // R8: SDA toggles under low SCL form no START.
        data_bits(6);
        bus_stop();
        hold(3);
        chk("R8 data bits not a condition", wdo_n, 1'b0);

        // R7: repeated START then STOP.
        bus_start();
        sda = 1'b1; hold(3);
        scl = 1'b1; hold(3);
        sda = 1'b0; hold(3);
        scl = 1'b0; hold(3);
        bus_stop();
        chk("R7 repeated start then stop", wdo_n, 1'b1);

        // R9 and R5: write while timed out, then measure 64 and 256.
        hold(20);
        chk("R10 low before write", wdo_n, 1'b0);
        write_sel(2'b01);
        chk("R9 write releases", wdo_n, 1'b1);
        expect_fall("R5 period 01", 64);
        write_sel(2'b10);
        chk("R9 write releases again", wdo_n, 1'b1);
        expect_fall("R5 period 10", 256);

        // R6: disabled.
        write_sel(2'b11);
        hold(300);
        chk("R6 disabled stays high", wdo_n, 1'b1);
        write_sel(2'b00);
        expect_fall("R4 period 00 after write", 16);

        // R10: stays low with no service.
        hold(50);
        chk("R10 stays low", wdo_n, 1'b0);

        // R1: reset mid-run restores code 00.
        write_sel(2'b10);
        hold(5);
        @(negedge clk); rst_n = 1'b0;
        hold(2);
        rst_n = 1'b1;
        chk("R1 high after reset", wdo_n, 1'b1);
        expect_fall("R1 code 00 after reset", 16);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule